// File: doc/BRIEF.md
# Strobe-Based Multi-Bus Frame Aligner

This block lines up two or more parallel sample buses that a converter drives into one capture clock. Each bus delivers one sample word and one frame-start strobe bit on every cycle. The strobe repeats at a fixed spacing of `FRAME_LEN` samples. Board routing and independent capture leave the buses skewed against each other by a few cycles. The block removes that skew in logic, so that the traces do not have to be matched in length.

Every bus writes without pause into its own circular buffer. The buffer holds at least two frames. While searching, the block watches the incoming strobes. The first bus to show a strobe opens a short pairing window. Any bus that shows its strobe within `MAX_SKEW` cycles of that first strobe is paired with it. Once every bus is paired, each buffer starts reading at its own frame-start entry, and all buffers then advance together. Words sampled at the same instant therefore leave the block on the same cycle.

The frame position is checked on every word that is read out. A strobe that is missing, or one that arrives out of place, raises a one-cycle error and sends the block back to searching. Buses that belong to different groups (for instance two pairs) use one instance per group.

Top module: `strobe_frame_aligner`

## Requirements
- R1: A synchronous reset (`rst` high) clears `out_valid`, `aligned` and `align_err` from the next cycle and discards all buffered samples. After reset, no word is emitted until new strobes have been paired.
- R2: No word is emitted until every bus has shown a strobe on its input within `MAX_SKEW` cycles of the first strobe in the window. The first word emitted after pairing is the frame-start sample of every bus.
- R3: Once paired, `out_valid` is high on every cycle. Lane b occupies `out_data[b*DATA_W +: DATA_W]`. All lanes carry samples from the same instant, and successive words are consecutive samples. No `align_err` is raised while the strobes keep their spacing of `FRAME_LEN`.
- R4: Strobes that are further apart than `MAX_SKEW` cycles are never paired. A window closes after `MAX_SKEW` cycles, and a later strobe opens a fresh window.
- R5: `aligned` rises together with the first word of the second frame, which is word index `FRAME_LEN` of a valid run. It stays high while valid words continue and is low whenever `out_valid` is low.
- R6: If a strobe is missing at an expected frame start on any bus, `align_err` pulses for one cycle. The word read in that cycle is not emitted, `out_valid` is low in that cycle and the next, and `aligned` is cleared.
- R7: A strobe at a spacing other than `FRAME_LEN` (an extra strobe inside a frame) gives the same response as R6.
- R8: After an error the block pairs fresh strobes. Output resumes with a frame-start word, and `aligned` returns after two clean frames.
- R9: Skews within `MAX_SKEW` are absorbed whatever their order. The bus whose strobe is seen first waits for the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common capture clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | NUM_BUS*DATA_W | Sample word of each bus, bus b at bits [b*DATA_W +: DATA_W] |
| in_strb | input | NUM_BUS | Frame-start strobe of each bus, 1 on the first sample of a frame |
| out_data | output | NUM_BUS*DATA_W | Aligned sample words, same lane layout as in_data |
| out_valid | output | 1 | out_data holds one aligned word per lane this cycle |
| aligned | output | 1 | Two or more consecutive clean frames have been emitted |
| align_err | output | 1 | One-cycle pulse on a strobe mismatch; the block then searches again |

## Verification
The bench builds the block with three buses, 10-bit words, 8-sample frames and a pairing window of 3 cycles. Short frames let a single run hold many frame checks, an injected fault and a full reacquisition. Three buses allow a window to time out with only one straggler missing. The skew sets include one where the nearest strobes are 4 cycles apart in both directions, which is one cycle beyond the window. That case shows that the block never pairs them.

// File: rtl/fa_pkg.sv
package fa_pkg;

   typedef enum logic {
      ST_SEARCH = 1'b0,
      ST_RUN    = 1'b1
   } fa_state_e;

endpackage

// File: rtl/fa_lane_buf.sv
// One circular buffer per bus. The write side runs every cycle, and the read
// pointer is loaded once at pairing time and then advanced in lock step.
module fa_lane_buf #(
   parameter int DATA_W = 12,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_strb,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_ptr,
   input  logic              advance,
   output logic [DATA_W-1:0] head_data,
   output logic              head_strb,
   output logic [ADDR_W-1:0] wr_ptr
);

   localparam int DEPTH   = 1 << ADDR_W;
   localparam int ENTRY_W = DATA_W + 1;

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0]  rd_ptr;

   always_ff @(posedge clk) begin
      if (!rst) begin
         mem[wr_ptr] <= {wr_strb, wr_data};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         wr_ptr <= wr_ptr + 1'b1;
         if (load) begin
            rd_ptr <= load_ptr;
         end else if (advance) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
      end
   end

   assign {head_strb, head_data} = mem[rd_ptr];

endmodule

// File: rtl/fa_acquire.sv
// Pairs the strobes seen at the buffer inputs. The first strobe opens a
// window of MAX_SKEW cycles. Each bus records the write address of its
// strobe, and lock fires once every bus has been seen.
module fa_acquire #(
   parameter int NUM_BUS  = 2,
   parameter int ADDR_W   = 5,
   parameter int MAX_SKEW = 7
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      enable,
   input  logic [NUM_BUS-1:0]        strb,
   input  logic [NUM_BUS*ADDR_W-1:0] wr_ptrs,
   output logic                      lock,
   output logic [NUM_BUS*ADDR_W-1:0] start_ptrs
);

   localparam int CNT_W = $clog2(MAX_SKEW + 1);

   logic [NUM_BUS-1:0]        seen;
   logic [NUM_BUS-1:0]        seen_nxt;
   logic [NUM_BUS*ADDR_W-1:0] rec;
   logic                      win_open;
   logic [CNT_W-1:0]          win_cnt;

   assign seen_nxt = seen | strb;
   assign lock     = enable && (&seen_nxt);

   always_comb begin
      for (int b = 0; b < NUM_BUS; b++) begin
         start_ptrs[b*ADDR_W +: ADDR_W] = seen[b] ? rec[b*ADDR_W +: ADDR_W]
                                                  : wr_ptrs[b*ADDR_W +: ADDR_W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rec <= '0;
      end else begin
         for (int b = 0; b < NUM_BUS; b++) begin
            if (strb[b] && !seen[b]) begin
               rec[b*ADDR_W +: ADDR_W] <= wr_ptrs[b*ADDR_W +: ADDR_W];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !enable || lock) begin
         seen     <= '0;
         win_open <= 1'b0;
         win_cnt  <= '0;
      end else if (!win_open) begin
         if (|strb) begin
            win_open <= 1'b1;
            seen     <= strb;
            win_cnt  <= CNT_W'(1);
         end
      end else if (win_cnt == CNT_W'(MAX_SKEW)) begin
         seen     <= '0;
         win_open <= 1'b0;
         win_cnt  <= '0;
      end else begin
         seen    <= seen_nxt;
         win_cnt <= win_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/fa_frame_check.sv
// Tracks the frame position of the words being read and compares every
// lane's strobe bit with it. Counts clean frame starts for the aligned flag.
module fa_frame_check #(
   parameter int NUM_BUS   = 2,
   parameter int FRAME_LEN = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               run,
   input  logic [NUM_BUS-1:0] head_strb,
   output logic               mismatch,
   output logic               aligned
);

   localparam int POS_W = $clog2(FRAME_LEN);

   logic [POS_W-1:0] pos;
   logic [1:0]       good_cnt;
   logic             at_start;

   assign at_start = (pos == '0);
   assign mismatch = run && (head_strb != {NUM_BUS{at_start}});

   always_ff @(posedge clk) begin
      if (rst || !run || mismatch) begin
         pos      <= '0;
         good_cnt <= '0;
         aligned  <= 1'b0;
      end else begin
         pos <= (pos == POS_W'(FRAME_LEN - 1)) ? '0 : pos + 1'b1;
         if (at_start && good_cnt != 2'd2) begin
            good_cnt <= good_cnt + 1'b1;
         end
         if (at_start && good_cnt != 2'd0) begin
            aligned <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/strobe_frame_aligner.sv
module strobe_frame_aligner #(
   parameter int NUM_BUS   = 2,
   parameter int DATA_W    = 12,
   parameter int FRAME_LEN = 16,
   parameter int MAX_SKEW  = FRAME_LEN / 2 - 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NUM_BUS*DATA_W-1:0] in_data,
   input  logic [NUM_BUS-1:0]        in_strb,
   output logic [NUM_BUS*DATA_W-1:0] out_data,
   output logic                      out_valid,
   output logic                      aligned,
   output logic                      align_err
);

   import fa_pkg::*;

   localparam int ADDR_W = $clog2(2 * FRAME_LEN);
   localparam int BUS_W  = NUM_BUS * DATA_W;
   localparam int PTR_W  = NUM_BUS * ADDR_W;

   if (NUM_BUS < 2) begin : g_chk_buses
      $error("strobe_frame_aligner: NUM_BUS must be at least 2");
   end
   if (DATA_W < 1) begin : g_chk_width
      $error("strobe_frame_aligner: DATA_W must be at least 1");
   end
   if (FRAME_LEN < 2) begin : g_chk_frame
      $error("strobe_frame_aligner: FRAME_LEN must be at least 2");
   end
   if (MAX_SKEW < 1 || 2 * MAX_SKEW >= FRAME_LEN) begin : g_chk_skew
      $error("strobe_frame_aligner: MAX_SKEW must lie in 1 .. FRAME_LEN/2 - 1");
   end

   fa_state_e          state;
   logic               run;
   logic               lock;
   logic               mismatch;
   logic [BUS_W-1:0]   head_data;
   logic [NUM_BUS-1:0] head_strb;
   logic [PTR_W-1:0]   wr_ptrs;
   logic [PTR_W-1:0]   start_ptrs;

   assign run = (state == ST_RUN);

   for (genvar g = 0; g < NUM_BUS; g++) begin : g_lane
      fa_lane_buf #(
         .DATA_W (DATA_W),
         .ADDR_W (ADDR_W)
      ) i_lane (
         .clk       (clk),
         .rst       (rst),
         .wr_data   (in_data[g*DATA_W +: DATA_W]),
         .wr_strb   (in_strb[g]),
         .load      (lock),
         .load_ptr  (start_ptrs[g*ADDR_W +: ADDR_W]),
         .advance   (run),
         .head_data (head_data[g*DATA_W +: DATA_W]),
         .head_strb (head_strb[g]),
         .wr_ptr    (wr_ptrs[g*ADDR_W +: ADDR_W])
      );
   end

   fa_acquire #(
      .NUM_BUS  (NUM_BUS),
      .ADDR_W   (ADDR_W),
      .MAX_SKEW (MAX_SKEW)
   ) i_acquire (
      .clk        (clk),
      .rst        (rst),
      .enable     (!run),
      .strb       (in_strb),
      .wr_ptrs    (wr_ptrs),
      .lock       (lock),
      .start_ptrs (start_ptrs)
   );

   fa_frame_check #(
      .NUM_BUS   (NUM_BUS),
      .FRAME_LEN (FRAME_LEN)
   ) i_check (
      .clk       (clk),
      .rst       (rst),
      .run       (run),
      .head_strb (head_strb),
      .mismatch  (mismatch),
      .aligned   (aligned)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_SEARCH;
      end else begin
         case (state)
            ST_SEARCH: if (lock)     state <= ST_RUN;
            ST_RUN:    if (mismatch) state <= ST_SEARCH;
            default:                 state <= ST_SEARCH;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_data  <= '0;
         out_valid <= 1'b0;
         align_err <= 1'b0;
      end else begin
         out_valid <= run && !mismatch;
         align_err <= mismatch;
         if (run && !mismatch) begin
            out_data <= head_data;
         end
      end
   end

endmodule

// File: rtl/strobe_frame_aligner_chk.sv
module strobe_frame_aligner_chk (
   input logic clk,
   input logic rst,
   input logic out_valid,
   input logic aligned,
   input logic align_err
);

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_valid && !aligned && !align_err));

   a_r5_aligned_needs_valid: assert property (@(posedge clk) disable iff (rst)
      aligned |-> out_valid);

   a_r5_first_word_not_aligned: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> !aligned);

   a_r6_err_drops_word: assert property (@(posedge clk) disable iff (rst)
      align_err |-> (!out_valid && !aligned));

   a_r6_err_then_idle: assert property (@(posedge clk) disable iff (rst)
      align_err |=> !out_valid);

   a_r6_aligned_fall_cause: assert property (@(posedge clk) disable iff (rst)
      $fell(aligned) |-> (align_err || $past(rst)));

endmodule

bind strobe_frame_aligner strobe_frame_aligner_chk i_chk (
   .clk       (clk),
   .rst       (rst),
   .out_valid (out_valid),
   .aligned   (aligned),
   .align_err (align_err)
);

// File: tb/test_strobe_frame_aligner.sv
`timescale 1ns/1ps
module test_strobe_frame_aligner;

   localparam int NB = 3;
   localparam int DW = 10;
   localparam int FL = 8;
   localparam int MS = 3;
   localparam int NVEC = 7;
   localparam int SCN_CYC = 220;

   typedef struct packed {
      logic [3:0] sk0;
      logic [3:0] sk1;
      logic [3:0] sk2;
      logic [1:0] ftype;   // 0 none, 1 missing strobe, 2 extra strobe
      logic [1:0] fbus;
      logic       exp_lock;
      logic [1:0] exp_err;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{4'd0, 4'd0, 4'd0, 2'd0, 2'd0, 1'b1, 2'd0},
      '{4'd0, 4'd2, 4'd3, 2'd0, 2'd0, 1'b1, 2'd0},
      '{4'd3, 4'd0, 4'd1, 2'd1, 2'd1, 1'b1, 2'd1},
      '{4'd2, 4'd3, 4'd0, 2'd2, 2'd2, 1'b1, 2'd1},
      '{4'd1, 4'd3, 4'd2, 2'd1, 2'd0, 1'b1, 2'd1},
      '{4'd0, 4'd0, 4'd4, 2'd0, 2'd0, 1'b0, 2'd0},
      '{4'd0, 4'd1, 4'd0, 2'd2, 2'd0, 1'b1, 2'd1}
   };

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [NB*DW-1:0]   in_data = '0;
   logic [NB-1:0]      in_strb = '0;
   logic [NB*DW-1:0]   out_data;
   logic               out_valid;
   logic               aligned;
   logic               align_err;

   int tests = 0;
   int fails = 0;
   int t = 0;
   int skew [NB];
   int ftype = 0;
   int fbus = 0;
   logic [NB-1:0] strb_en = '1;

   int  run_n, prev_word, err_cnt;
   bit  prev_valid, prev_err, saw_valid, after_err_valid, after_err_aligned;
   int  bad_eq, bad_seq, bad_first, bad_aligned, bad_errrule;

   always #4 clk = ~clk;

   strobe_frame_aligner #(
      .NUM_BUS   (NB),
      .DATA_W    (DW),
      .FRAME_LEN (FL),
      .MAX_SKEW  (MS)
   ) i_strobe_frame_aligner (
      .clk       (clk),
      .rst       (rst),
      .in_data   (in_data),
      .in_strb   (in_strb),
      .out_data  (out_data),
      .out_valid (out_valid),
      .aligned   (aligned),
      .align_err (align_err)
   );

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Bus b sees sample tau = t + 16 - skew[b]; its strobe marks tau % FL == 0.
   task automatic apply(input int tt);
      for (int b = 0; b < NB; b++) begin
         int  tau;
         bit  s;
         tau = tt + 16 - skew[b];
         s   = ((tau % FL) == 0) && strb_en[b];
         if (ftype == 1 && b == fbus && tau == 120) s = 1'b0;
         if (ftype == 2 && b == fbus && tau == 122) s = 1'b1;
         in_data[b*DW +: DW] = DW'(tau);
         in_strb[b] = s;
      end
   endtask

   task automatic clear_monitor();
      run_n = 0; prev_word = 0; err_cnt = 0;
      prev_valid = 0; prev_err = 0; saw_valid = 0;
      after_err_valid = 0; after_err_aligned = 0;
      bad_eq = 0; bad_seq = 0; bad_first = 0; bad_aligned = 0; bad_errrule = 0;
   endtask

   task automatic monitor();
      logic [DW-1:0] w0;
      w0 = out_data[DW-1:0];
      if (out_valid) begin
         saw_valid = 1;
         for (int b = 1; b < NB; b++) begin
            if (out_data[b*DW +: DW] != w0) bad_eq++;
         end
         if (prev_valid) begin
            if (w0 != DW'(prev_word + 1)) bad_seq++;
            run_n++;
         end else begin
            run_n = 0;
            if ((int'(w0) % FL) != 0) bad_first++;
         end
         if (aligned != (run_n >= FL)) bad_aligned++;
         if (err_cnt > 0) after_err_valid = 1;
         if (err_cnt > 0 && aligned) after_err_aligned = 1;
      end else begin
         if (aligned) bad_aligned++;
      end
      if (align_err) begin
         err_cnt++;
         if (out_valid) bad_errrule++;
      end
      if (prev_err && out_valid) bad_errrule++;
      prev_valid = out_valid;
      prev_word  = int'(w0);
      prev_err   = align_err;
   endtask

   task automatic start_reset();
      @(negedge clk);
      rst = 1'b1;
      in_data = '0;
      in_strb = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t = 0;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         apply(t);
         t++;
         @(negedge clk);
         monitor();
      end
   endtask

   initial begin : watchdog
      #(8 * 150000);
      tests++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      int vcount;
      // R1: state at time zero under reset
      repeat (2) @(negedge clk);
      check_eq("R1", "out_valid in reset", int'(out_valid), 0);
      check_eq("R1", "aligned in reset", int'(aligned), 0);
      check_eq("R1", "align_err in reset", int'(align_err), 0);

      // Table of skew and fault vectors
      for (int v = 0; v < NVEC; v++) begin
         skew[0] = int'(VECS[v].sk0);
         skew[1] = int'(VECS[v].sk1);
         skew[2] = int'(VECS[v].sk2);
         ftype   = int'(VECS[v].ftype);
         fbus    = int'(VECS[v].fbus);
         strb_en = '1;
         start_reset();
         clear_monitor();
         step(SCN_CYC);
         check_eq("R3", "lanes differing", bad_eq, 0);
         check_eq("R3", "non-consecutive words", bad_seq, 0);
         check_eq("R2", "first word off frame start", bad_first, 0);
         check_eq("R5", "aligned timing errors", bad_aligned, 0);
         if (VECS[v].exp_lock)
            check_eq("R9", "lock reached", int'(saw_valid), 1);
         else
            check_eq("R4", "lock reached", int'(saw_valid), 0);
         if (ftype == 1)
            check_eq("R6", "error pulses", err_cnt, int'(VECS[v].exp_err));
         else if (ftype == 2)
            check_eq("R7", "error pulses", err_cnt, int'(VECS[v].exp_err));
         else
            check_eq("R3", "spurious error pulses", err_cnt, 0);
         if (ftype != 0) begin
            check_eq("R6", "word emitted around error", bad_errrule, 0);
            check_eq("R8", "valid after reacquire", int'(after_err_valid), 1);
            check_eq("R8", "aligned after reacquire", int'(after_err_aligned), 1);
         end
      end

      // Directed: reset while aligned, then strobe starvation
      skew[0] = 0; skew[1] = 2; skew[2] = 3;
      ftype = 0;
      strb_en = '1;
      start_reset();
      clear_monitor();
      step(80);
      check_eq("R5", "aligned before mid-run reset", int'(aligned), 1);
      rst = 1'b1;
      @(negedge clk);
      check_eq("R1", "out_valid after reset", int'(out_valid), 0);
      check_eq("R1", "aligned after reset", int'(aligned), 0);
      check_eq("R1", "align_err after reset", int'(align_err), 0);
      rst = 1'b0;
      strb_en = '0;
      vcount = 0;
      for (int i = 0; i < 40; i++) begin
         apply(t); t++;
         @(negedge clk);
         if (out_valid) vcount++;
      end
      check_eq("R1", "words with no strobes after reset", vcount, 0);
      strb_en = 3'b011;
      vcount = 0;
      for (int i = 0; i < 40; i++) begin
         apply(t); t++;
         @(negedge clk);
         if (out_valid) vcount++;
      end
      check_eq("R2", "words with one bus silent", vcount, 0);
      strb_en = '1;
      vcount = 0;
      for (int i = 0; i < 40; i++) begin
         apply(t); t++;
         @(negedge clk);
         if (out_valid) vcount++;
      end
      check_eq("R2", "lock once all buses strobe", int'(vcount > 0), 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule